// File: doc/BRIEF.md
# Serial Key Unlock Detector

This block sits beside an ordinary memory and watches its bus strobes. The strobes are chip enable, output enable and write enable, all active low. It also watches the address and data bit 0. It decides when software has presented a secret 64-bit key as a stream of single-bit writes. A completed read cycle arms the detector. Each completed write cycle that follows, to an address below 0x80000, gives one key bit on data bit 0. The bits are compared in order, starting with key bit 0. When all 64 bits match, an unlock flag is raised. That flag opens a window of 64 access cycles, in which a hidden timekeeping register may be reached.

The detector never blocks the memory. The write strobe passes through unchanged, so the key writes also land in memory. A scratch location is normally set aside for them. The strobes arrive without a clock. They pass through a synchroniser, and a cycle is acted on when its strobes are released.

Top module: `key_unlock`

## Requirements
- R1: After a synchronous active-high reset, `ptr` is 0, `armed` is 0 and `unlock` is 0.
- R2: A completed read cycle arms the detector and sets `ptr` to 0. A read cycle is one in which `ce_n` and `oe_n` are both low, and it completes when either strobe rises. The address does not matter, and this also applies in the middle of a sequence. The effect appears at the outputs on the third rising clock edge after the release.
- R3: While armed, a completed write cycle (`ce_n` and `we_n` both low) to an address below 0x80000 whose `wdata0` equals key bit `ptr` (bit i is `KEY[i]`) increments `ptr` by one.
- R4: While armed, a completed in-range write whose `wdata0` differs from key bit `ptr` returns `ptr` to 0 and clears `armed`. Further writes then have no effect until the next completed read.
- R5: Write cycles to addresses of 0x80000 or above change neither `ptr` nor `armed`.
- R6: Write cycles completed while not armed change nothing.
- R7: A match on key bit 63 sets `unlock` to 1, sets `ptr` to 64 and clears `armed`. `ptr` then stays at 64 while unlocked.
- R8: While unlocked, every completed read or write cycle counts as one window access, whatever its address and data, and reads do not re-arm. On the 64th access, `unlock`, `ptr` and `armed` all return to 0.
- R9: When a read cycle and a write cycle complete in the same clock, the read wins. The detector re-arms with `ptr` 0 and the write bit is not compared. Inside the window, the pair counts as a single access.
- R10: `mem_we_n` always equals `we_n`, so key writes still reach memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Memory chip enable, active low, asynchronous |
| oe_n | input | 1 | Memory output enable, active low, asynchronous |
| we_n | input | 1 | Memory write enable, active low, asynchronous |
| addr | input | ADDR_W (21) | Memory address |
| wdata0 | input | 1 | Data bus bit 0 |
| mem_we_n | output | 1 | Write strobe passed through to the memory |
| armed | output | 1 | Detector armed by a read and accepting key bits |
| unlock | output | 1 | Key matched; access window open |
| ptr | output | 7 | Index of the next key bit (64 while unlocked) |

## Verification
A read completion and a write completion can land in the same clock. The bench provokes this by pulling chip enable, output enable and write enable low together and then raising only chip enable, which ends both cycles at once. It does this once partway through a key sequence and once at the final access of an open window. In the first case, `ptr` must drop to 0 with `armed` set, and the offered bit must be ignored. In the second case, the window must close after exactly 64 counted accesses, with the pair counted once.

// File: rtl/ku_pkg.sv
package ku_pkg;

    // Synchronised bus sample: strobes, address-range hit, data bit 0
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic hit;
        logic d0;
    } bus_smp_t;

    localparam int SMP_W = $bits(bus_smp_t);
    localparam logic [SMP_W-1:0] SMP_IDLE = 5'b11100;

    // Cycle-end detector state
    typedef struct packed {
        logic rd_act;
        logic wr_act;
        logic dbit;
        logic hit;
    } evt_st_t;

endpackage

// File: rtl/ku_sync.sv
module ku_sync #(
    parameter int              WIDTH   = 5,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg_q[g] <= RST_VAL;
                else     stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/ku_event.sv
module ku_event
    import ku_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_smp_t smp,
    output logic     rd_end,
    output logic     wr_end,
    output logic     wr_bit,
    output logic     wr_hit
);

    evt_st_t st_d, st_q;
    logic    rd_now, wr_now;

    always_comb begin
        rd_now = !smp.ce_n && !smp.oe_n;
        wr_now = !smp.ce_n && !smp.we_n;
        st_d        = st_q;
        st_d.rd_act = rd_now;
        st_d.wr_act = wr_now;
        if (wr_now) begin
            st_d.dbit = smp.d0;
            st_d.hit  = smp.hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // A cycle ends when its qualifying strobe pair is released
    assign rd_end = st_q.rd_act && !rd_now;
    assign wr_end = st_q.wr_act && !wr_now;
    assign wr_bit = st_q.dbit;
    assign wr_hit = st_q.hit;

endmodule

// File: rtl/ku_match.sv
module ku_match #(
    parameter int              KEY_W      = 64,
    parameter logic [KEY_W-1:0] KEY        = 64'hD3A5_96C3_5A0F_E1B7,
    parameter int              WINDOW_LEN = 64,
    localparam int             PTR_W      = $clog2(KEY_W + 1),
    localparam int             IDX_W      = $clog2(KEY_W),
    localparam int             WIN_W      = $clog2(WINDOW_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_end,
    input  logic             wr_end,
    input  logic             wr_bit,
    input  logic             wr_hit,
    output logic             armed,
    output logic             unlock,
    output logic [PTR_W-1:0] ptr
);

    typedef struct packed {
        logic             armed;
        logic             unlock;
        logic [PTR_W-1:0] ptr;
        logic [WIN_W-1:0] win;
    } mst_t;

    mst_t st_d, st_q;
    logic key_bit;
    logic any_end;

    always_comb begin
        key_bit = KEY[st_q.ptr[IDX_W-1:0]];
        any_end = rd_end || wr_end;
        st_d    = st_q;
        if (st_q.unlock) begin
            if (any_end) begin
                if (st_q.win == WIN_W'(WINDOW_LEN - 1)) begin
                    st_d = '0;
                end else begin
                    st_d.win = st_q.win + WIN_W'(1);
                end
            end
        end else if (rd_end) begin
            st_d.armed = 1'b1;
            st_d.ptr   = '0;
        end else if (wr_end && st_q.armed && wr_hit) begin
            if (wr_bit == key_bit) begin
                if (st_q.ptr == PTR_W'(KEY_W - 1)) begin
                    st_d.unlock = 1'b1;
                    st_d.armed  = 1'b0;
                    st_d.ptr    = PTR_W'(KEY_W);
                    st_d.win    = '0;
                end else begin
                    st_d.ptr = st_q.ptr + PTR_W'(1);
                end
            end else begin
                st_d.armed = 1'b0;
                st_d.ptr   = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign armed  = st_q.armed;
    assign unlock = st_q.unlock;
    assign ptr    = st_q.ptr;

endmodule

// File: rtl/key_unlock.sv
module key_unlock
    import ku_pkg::*;
#(
    parameter int                ADDR_W      = 21,
    parameter logic [ADDR_W-1:0] HIT_LIMIT   = 21'h80000,
    parameter int                KEY_W       = 64,
    parameter logic [KEY_W-1:0]  KEY         = 64'hD3A5_96C3_5A0F_E1B7,
    parameter int                SYNC_STAGES = 2,
    parameter int                WINDOW_LEN  = 64,
    localparam int               PTR_W       = $clog2(KEY_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wdata0,
    output logic              mem_we_n,
    output logic              armed,
    output logic              unlock,
    output logic [PTR_W-1:0]  ptr
);

    bus_smp_t raw_smp, syn_smp;
    logic     rd_end, wr_end, wr_bit, wr_hit;

    always_comb begin
        raw_smp.ce_n = ce_n;
        raw_smp.oe_n = oe_n;
        raw_smp.we_n = we_n;
        raw_smp.hit  = (addr < HIT_LIMIT);
        raw_smp.d0   = wdata0;
    end

    // Memory write is never gated
    assign mem_we_n = we_n;

    ku_sync #(
        .WIDTH  (SMP_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SMP_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_smp),
        .dout(syn_smp)
    );

    ku_event u_event (
        .clk   (clk),
        .rst   (rst),
        .smp   (syn_smp),
        .rd_end(rd_end),
        .wr_end(wr_end),
        .wr_bit(wr_bit),
        .wr_hit(wr_hit)
    );

    ku_match #(
        .KEY_W     (KEY_W),
        .KEY       (KEY),
        .WINDOW_LEN(WINDOW_LEN)
    ) u_match (
        .clk   (clk),
        .rst   (rst),
        .rd_end(rd_end),
        .wr_end(wr_end),
        .wr_bit(wr_bit),
        .wr_hit(wr_hit),
        .armed (armed),
        .unlock(unlock),
        .ptr   (ptr)
    );

endmodule

// File: rtl/ku_chk.sv
module ku_chk #(
    parameter int  KEY_W = 64,
    localparam int PTR_W = $clog2(KEY_W + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             armed,
    input logic             unlock,
    input logic [PTR_W-1:0] ptr
);

    // R7
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_W'(KEY_W));

    // R7
    unlock_parked_chk: assert property (@(posedge clk) disable iff (rst)
        unlock |-> (!armed && ptr == PTR_W'(KEY_W)));

    // R7
    unlock_after_last_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(unlock) |-> $past(ptr) == PTR_W'(KEY_W - 1));

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!unlock && ptr != 0 && ptr != $past(ptr)) |-> ptr == $past(ptr) + PTR_W'(1));

    // R4
    idle_ptr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed && !unlock) |-> ptr == '0);

endmodule

bind key_unlock ku_chk #(.KEY_W(KEY_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .armed (armed),
    .unlock(unlock),
    .ptr   (ptr)
);

// File: tb/key_unlock_tb.sv
module key_unlock_tb;

    localparam logic [63:0] TB_KEY = 64'h9E37_79B9_7F4A_7C15;
    localparam int          WIN    = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [20:0] addr = '0;
    logic        wdata0 = 1'b0;
    logic        mem_we_n, armed, unlock;
    logic [6:0]  ptr;

    int n_cmp = 0;
    int n_bad = 0;

    bit m_armed, m_unlock;
    int m_ptr, m_win;

    always #5 clk = ~clk;

    key_unlock #(.KEY(TB_KEY)) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .wdata0(wdata0), .mem_we_n(mem_we_n),
        .armed(armed), .unlock(unlock), .ptr(ptr)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chk_state(input string tag);
        chk(tag, "ptr", int'(ptr), m_ptr);
        chk(tag, "armed", int'(armed), int'(m_armed));
        chk(tag, "unlock", int'(unlock), int'(m_unlock));
    endtask

    function automatic bit kbit(input int i);
        return TB_KEY[i];
    endfunction

    task automatic model_step(input bit rd, input bit wr, input bit b, input bit h);
        if (m_unlock) begin
            if (rd || wr) begin
                if (m_win == WIN - 1) begin
                    m_unlock = 0; m_armed = 0; m_ptr = 0; m_win = 0;
                end else m_win++;
            end
        end else if (rd) begin
            m_armed = 1; m_ptr = 0;
        end else if (wr && m_armed && h) begin
            if (b == kbit(m_ptr)) begin
                if (m_ptr == 63) begin
                    m_unlock = 1; m_armed = 0; m_ptr = 64; m_win = 0;
                end else m_ptr++;
            end else begin
                m_armed = 0; m_ptr = 0;
            end
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [20:0] a, input bit d);
        @(negedge clk);
        addr = a; wdata0 = d; ce_n = 0; we_n = 0;
        #1 chk("R10", "mem_we_n low", int'(mem_we_n), 0);
        repeat (3) @(negedge clk);
        ce_n = 1; we_n = 1;
        #1 chk("R10", "mem_we_n high", int'(mem_we_n), 1);
        model_step(0, 1, d, a < 21'h80000);
        settle();
    endtask

    task automatic bus_read(input logic [20:0] a);
        @(negedge clk);
        addr = a; ce_n = 0; oe_n = 0;
        repeat (3) @(negedge clk);
        ce_n = 1; oe_n = 1;
        model_step(1, 0, 0, 1);
        settle();
    endtask

    task automatic bus_both(input logic [20:0] a, input bit d);
        @(negedge clk);
        addr = a; wdata0 = d; oe_n = 0; we_n = 0; ce_n = 0;
        repeat (3) @(negedge clk);
        ce_n = 1;
        @(negedge clk);
        oe_n = 1; we_n = 1;
        model_step(1, 1, d, a < 21'h80000);
        settle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; ce_n = 1; oe_n = 1; we_n = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        m_armed = 0; m_unlock = 0; m_ptr = 0; m_win = 0;
        @(negedge clk);
    endtask

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary_and_end();
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        chk_state("R1");

        // R6: writes before arming
        bus_write(21'h00010, kbit(0));
        chk_state("R6");

        // R2: arm from a high address
        bus_read(21'h1FFFF0);
        chk_state("R2");

        // R3: five matching bits
        for (int i = 0; i < 5; i++) bus_write(21'h00040, kbit(i));
        chk_state("R3");
        chk("R3", "ptr after 5", int'(ptr), 5);

        // R5: out-of-range write with the wrong bit
        bus_write(21'h080000, !kbit(5));
        chk_state("R5");
        chk("R5", "ptr held", int'(ptr), 5);

        // R2: read mid-sequence rearms
        bus_read(21'h00040);
        chk("R2", "ptr rearm", int'(ptr), 0);
        chk_state("R2");

        // R4: mismatch then ignored
        bus_write(21'h00040, !kbit(0));
        chk_state("R4");
        bus_write(21'h00040, kbit(0));
        chk("R4", "ptr stays 0", int'(ptr), 0);
        chk("R4", "armed stays 0", int'(armed), 0);

        // R4: mismatch on the final bit
        bus_read(21'h0);
        for (int i = 0; i < 63; i++) bus_write(21'h00040, kbit(i));
        chk("R4", "ptr at 63", int'(ptr), 63);
        bus_write(21'h00040, !kbit(63));
        chk_state("R4");

        // R7: full unlock
        bus_read(21'h0);
        for (int i = 0; i < 64; i++) bus_write(21'h00040, kbit(i));
        chk("R7", "unlock", int'(unlock), 1);
        chk("R7", "ptr 64", int'(ptr), 64);
        chk_state("R7");

        // R8: window of 64 accesses, reads do not rearm
        for (int i = 0; i < 63; i++) begin
            if (i % 3 == 0) bus_read(21'h100000);
            else bus_write(21'h1F0000, 1'b1);
        end
        chk("R8", "still unlocked at 63", int'(unlock), 1);
        chk("R7", "ptr parked", int'(ptr), 64);
        bus_read(21'h00040);
        chk("R8", "closed at 64", int'(unlock), 0);
        chk_state("R8");

        // R9: coincident read and write end mid-sequence
        bus_read(21'h0);
        for (int i = 0; i < 3; i++) bus_write(21'h00040, kbit(i));
        bus_both(21'h00040, kbit(3));
        chk("R9", "ptr back to 0", int'(ptr), 0);
        chk("R9", "armed", int'(armed), 1);
        chk_state("R9");

        // R9: coincident pair counted once in window
        for (int i = 0; i < 64; i++) bus_write(21'h00040, kbit(i));
        chk("R7", "unlock again", int'(unlock), 1);
        for (int i = 0; i < 63; i++) bus_write(21'h00040, 1'b0);
        chk("R9", "open before pair", int'(unlock), 1);
        bus_both(21'h00040, 1'b0);
        chk("R9", "closed by pair", int'(unlock), 0);
        chk_state("R9");

        // Random traffic against the model
        for (int n = 0; n < 900; n++) begin
            int r = int'($urandom % 100);
            if (r < 8 || (!m_armed && !m_unlock && r < 40)) begin
                bus_read(21'($urandom));
            end else if (r < 12) begin
                bus_both(21'($urandom % 21'h80000), 1'($urandom));
            end else if (r < 20) begin
                bus_write(21'h80000 + 21'($urandom % 21'h17FFFF), 1'($urandom));
            end else if (r < 23) begin
                bus_write(21'($urandom % 21'h80000), m_ptr < 64 ? !kbit(m_ptr) : 1'b0);
            end else begin
                bus_write(21'($urandom % 21'h80000), m_ptr < 64 ? kbit(m_ptr) : 1'b1);
            end
            chk_state("R3");
        end

        // R1: reset mid-sequence
        bus_read(21'h0);
        for (int i = 0; i < 10; i++) bus_write(21'h00040, kbit(i));
        do_reset();
        chk_state("R1");

        summary_and_end();
    end

endmodule